// File: doc/BRIEF.md
# Receive Pad Stripping Filter

This block sits in the receive byte path, after the MAC deserializer and before the FIFO that feeds host memory. Each frame comes in as a byte stream. The first byte carries a start marker and the last byte carries an end marker. The block reads the 802.3 length/type field of each frame. When stripping is enabled and that field gives a payload length below the 46-byte minimum, the block ends the frame once the real payload has been forwarded. It discards the pad and any trailing bytes, so they never cost bus bandwidth toward the host.

When stripping is disabled, or the field gives 46 or more, every byte passes unchanged. A value of 0x0600 or more is a type code and always falls in this case. Short frames are still forwarded. Every forwarded byte appears exactly one clock after it was accepted. The byte that closes a frame on the output also carries the number of bytes forwarded for that frame.

A controller steps through five named states:
- IDLE: no frame is open.
- HEADER: the 14 header bytes are being counted.
- TRIM: a payload with a known length is being forwarded.
- THRU: an unlimited pass-through is in progress.
- SKIP: the rest of a cut frame is being discarded.

The transitions are:
- A start marker goes to HEADER from any state.
- The last header byte goes to TRIM for a length of 1 to 45, to SKIP for a length of 0, or to THRU otherwise.
- The last counted payload byte goes from TRIM to SKIP.
- An end marker returns any state to IDLE.

Top module: `padstrip_rx_filter`

## Requirements
- R1: After reset, out_valid, out_sof and out_eof are low and out_count is zero.
- R2: Every forwarded byte appears on out_data exactly one clock after it was presented on in_data, with its value unchanged.
- R3: If strip_en is low at the start byte, every byte of the frame is forwarded, including frames shorter than 64 bytes. out_eof marks the input's last byte.
- R4: The length/type field is frame bytes 12 (most significant) and 13 (least significant), counting the start byte as byte 0.
- R5: If strip_en is high at the start byte and the length is between 1 and 45, the output frame ends with out_eof on byte 13+length. Input bytes after that, up to and including the end byte, are not forwarded.
- R6: A length/type value of 46 or more, including type codes of 0x0600 and above, is never stripped.
- R7: A stripped frame with length 0 ends with out_eof on byte 13, the second length byte.
- R8: On the cycle out_eof is high, out_count equals the number of bytes forwarded for that frame (14+length for a stripped frame).
- R9: An input frame that ends before its cut point, or before the length field is complete, closes the output frame on its own end byte.
- R10: Bytes presented with in_valid high while no frame is open (after an end byte and before the next start byte) are not forwarded.
- R11: Changing strip_en after the start byte has no effect on the frame in progress.
- R12: A start byte arriving inside an open frame begins a new frame. out_sof is asserted again and no out_eof is produced for the abandoned frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strip_en | input | 1 | Enables pad stripping; sampled on each start byte |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Input byte is the first of a frame |
| in_eof | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | Output byte is the first of a frame |
| out_eof | output | 1 | Output byte is the last of a frame |
| out_count | output | 16 | Bytes forwarded for the frame; meaningful when out_eof is high |

## Verification
Every result of this block, whether a forwarded byte, its markers or the frame count, is due one clock after the input byte that causes it. A suppressed byte shows as out_valid low in that same slot. The bench drives each input byte on a falling edge and records the outcome the requirements predict for that byte. It compares that prediction with the outputs at the next falling edge, after exactly one rising edge has passed, so every cycle is checked, idle gaps included. The predictions come from a frame-level rule: the cut point is 14 plus the length when stripping applies. The bench never reproduces the controller's states.

// File: rtl/rxps_pkg.sv
package rxps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_TRIM,
        ST_THRU,
        ST_SKIP
    } rxps_state_e;
endpackage

// File: rtl/rxps_len_probe.sv
module rxps_len_probe #(
    parameter int MIN_DATA = 46
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_hi,
    input  logic [7:0]  in_data,
    input  logic        strip_frame,
    output logic [15:0] len_val,
    output logic        trim_req
);
    logic [7:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      hi_q <= '0;
        else if (cap_hi) hi_q <= in_data;
    end

    // Most significant byte was captured one byte earlier.
    assign len_val  = {hi_q, in_data};
    assign trim_req = strip_frame && (len_val < 16'(MIN_DATA));
endmodule

// File: rtl/rxps_seq.sv
module rxps_seq
    import rxps_pkg::*;
#(
    parameter int HDR_LEN  = 14,
    parameter int MIN_DATA = 46
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strip_en,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [15:0] len_val,
    input  logic        trim_req,
    output logic        cap_hi,
    output logic        strip_frame,
    output logic        emit,
    output logic        emit_eof
);
    localparam int HIDX_W = $clog2(HDR_LEN);
    localparam int REM_W  = $clog2(MIN_DATA);
    localparam logic [HIDX_W-1:0] LAST_HDR = HIDX_W'(HDR_LEN - 1);
    localparam logic [HIDX_W-1:0] HI_IDX   = HIDX_W'(HDR_LEN - 2);

    rxps_state_e       state_q, state_d, cur;
    logic [HIDX_W-1:0] idx_q, idx_d, idx_c;
    logic [REM_W-1:0]  rem_q, rem_d;
    logic              strip_q, strip_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            rem_q   <= '0;
            strip_q <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            rem_q   <= rem_d;
            strip_q <= strip_d;
        end
    end

    always_comb begin
        cur         = (in_valid && in_sof) ? ST_HEADER : state_q;
        idx_c       = (in_valid && in_sof) ? '0 : idx_q;
        strip_frame = (in_valid && in_sof) ? strip_en : strip_q;
        state_d     = state_q;
        idx_d       = idx_q;
        rem_d       = rem_q;
        strip_d     = strip_q;
        cap_hi      = 1'b0;
        emit        = 1'b0;
        emit_eof    = 1'b0;
        if (in_valid) begin
            unique case (cur)
                ST_IDLE: ;
                ST_HEADER: begin
                    emit    = 1'b1;
                    strip_d = strip_frame;
                    cap_hi  = (idx_c == HI_IDX);
                    if (idx_c == LAST_HDR) begin
                        if (!trim_req) begin
                            state_d = ST_THRU;
                        end else if (len_val == 16'd0) begin
                            emit_eof = 1'b1;
                            state_d  = ST_SKIP;
                        end else begin
                            rem_d   = len_val[REM_W-1:0];
                            state_d = ST_TRIM;
                        end
                    end else begin
                        idx_d   = idx_c + 1'b1;
                        state_d = ST_HEADER;
                    end
                end
                ST_TRIM: begin
                    emit  = 1'b1;
                    rem_d = rem_q - 1'b1;
                    if (rem_q == REM_W'(1)) begin
                        emit_eof = 1'b1;
                        state_d  = ST_SKIP;
                    end
                end
                ST_THRU: emit = 1'b1;
                ST_SKIP: ;
            endcase
            if (in_eof) begin
                emit_eof = emit;
                state_d  = ST_IDLE;
            end
        end
    end

    // R5: a payload countdown never sits at zero
    p_trim_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIM) |-> (rem_q != '0));
    // R4: header index stays inside the header
    p_hdr_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEADER) |-> (idx_q <= LAST_HDR));
    // R3 / R11: discarding only happens in a frame that sampled stripping on
    p_skip_needs_strip_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> strip_q);
endmodule

// File: rtl/rxps_emit.sv
module rxps_emit #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             emit,
    input  logic             emit_eof,
    input  logic             in_sof,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic [CNT_W-1:0] out_count
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] base;

    assign base = in_sof ? '0 : cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            out_count <= '0;
            cnt_q     <= '0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit && in_sof;
            out_eof   <= emit && emit_eof;
            if (emit) begin
                out_data <= in_data;
                if (emit_eof) begin
                    out_count <= base + 1'b1;
                    cnt_q     <= '0;
                end else begin
                    cnt_q <= base + 1'b1;
                end
            end
        end
    end

    // R8: a closed frame always reports at least one byte
    p_count_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_eof |-> (out_count != '0));
endmodule

// File: rtl/padstrip_rx_filter.sv
module padstrip_rx_filter #(
    parameter int HDR_LEN  = 14,
    parameter int MIN_DATA = 46,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strip_en,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sof,
    input  logic             in_eof,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sof,
    output logic             out_eof,
    output logic [CNT_W-1:0] out_count
);
    logic [15:0] len_val;
    logic        trim_req, cap_hi, strip_frame, emit, emit_eof;

    rxps_len_probe #(.MIN_DATA(MIN_DATA)) u_probe (
        .clk(clk), .rst_n(rst_n), .cap_hi(cap_hi), .in_data(in_data),
        .strip_frame(strip_frame), .len_val(len_val), .trim_req(trim_req)
    );

    rxps_seq #(.HDR_LEN(HDR_LEN), .MIN_DATA(MIN_DATA)) u_seq (
        .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .len_val(len_val), .trim_req(trim_req),
        .cap_hi(cap_hi), .strip_frame(strip_frame), .emit(emit), .emit_eof(emit_eof)
    );

    rxps_emit #(.CNT_W(CNT_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .emit(emit), .emit_eof(emit_eof),
        .in_sof(in_sof), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_count(out_count)
    );

    // R2: an output byte implies an input byte one clock earlier
    p_follows_input_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));
    // R2: forwarded value is unchanged
    p_data_intact_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data)));
    // R10/R12: a start marker on the output came from a start marker on the input
    p_sof_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> $past(in_sof && in_valid));
endmodule

// File: tb/sim_padstrip_rx_filter.sv
`timescale 1ns/1ps
module sim_padstrip_rx_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strip_en = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        out_valid, out_sof, out_eof;
    logic [7:0]  out_data;
    logic [15:0] out_count;

    int errs = 0;
    int checks = 0;

    logic        e_valid = 1'b0, e_sof = 1'b0, e_eof = 1'b0;
    logic [7:0]  e_data = '0;
    logic [15:0] e_count = '0;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    padstrip_rx_filter u0 (
        .clk(clk), .rst_n(rst_n), .strip_en(strip_en), .in_valid(in_valid),
        .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_count(out_count)
    );

    task automatic compare();
        checks++;
        if (out_valid !== e_valid ||
            (e_valid && (out_data !== e_data || out_sof !== e_sof ||
                         out_eof !== e_eof || (e_eof && out_count !== e_count)))) begin
            errs++;
            $display("FAIL %s: got v=%0b d=%02h s=%0b e=%0b n=%0d expected v=%0b d=%02h s=%0b e=%0b n=%0d",
                     e_tag, out_valid, out_data, out_sof, out_eof, out_count,
                     e_valid, e_data, e_sof, e_eof, e_count);
        end
    endtask

    // Check the previous slot, then drive one slot and record its prediction.
    task automatic tick(input logic v, input logic [7:0] d, input logic s, input logic e,
                        input logic st, input logic ev, input logic es, input logic ee,
                        input int ecnt, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; in_data = d; in_sof = s; in_eof = e; strip_en = st;
        e_valid = ev; e_data = d; e_sof = es; e_eof = ee; e_count = 16'(ecnt); e_tag = tag;
    endtask

    task automatic idle(input int n, input string tag);
        for (int k = 0; k < n; k++) tick(1'b0, 8'h00, 1'b0, 1'b0, strip_en, 1'b0, 1'b0, 1'b0, 0, tag);
    endtask

    task automatic send_frame(input int n, input logic [15:0] len, input logic strip,
                              input bit has_eof, input int gap, input int toggle_at,
                              input string tag);
        int  cut;
        logic st;
        cut = (strip && n >= 14 && len < 16'd46) ? 14 + int'(len) : 1 << 30;
        st  = strip;
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            logic last, em, eo;
            b    = (i == 12) ? len[15:8] : (i == 13) ? len[7:0] : 8'(i * 13 + n);
            last = has_eof && (i == n - 1);
            em   = (i < cut);
            eo   = em && ((i == cut - 1) || last);
            if (i == toggle_at) st = ~strip;
            tick(1'b1, b, i == 0, last, st, em, i == 0, eo, i + 1, tag);
            if (gap > 0 && (i % gap) == gap - 1)
                tick(1'b0, 8'h00, 1'b0, 1'b0, st, 1'b0, 1'b0, 1'b0, 0, tag);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got run still active expected run complete");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        e_tag = "R1";
        compare();                                    // R1 during reset
        checks++;
        if (out_count !== 16'd0) begin
            errs++;
            $display("FAIL R1: got count=%0d expected 0", out_count);
        end
        rst_n = 1'b1;
        idle(2, "R1");
        send_frame(64, 16'd10, 1'b0, 1, 0, -1, "R3");    // strip off: all bytes
        send_frame(30, 16'd10, 1'b0, 1, 0, -1, "R3");    // short frame accepted
        send_frame(64, 16'd10, 1'b1, 1, 0, -1, "R5");    // cut after 24 bytes, R8 count
        idle(1, "R5");
        send_frame(64, 16'd46, 1'b1, 1, 0, -1, "R6");
        send_frame(70, 16'h0800, 1'b1, 1, 0, -1, "R6");
        send_frame(64, 16'd0, 1'b1, 1, 0, -1, "R7");
        send_frame(64, 16'd45, 1'b1, 1, 3, -1, "R5");     // with idle gaps
        send_frame(64, 16'h0105, 1'b1, 1, 0, -1, "R4");  // MSB first: 261, kept
        send_frame(64, 16'h0005, 1'b1, 1, 0, -1, "R4");  // 5: cut at 19 bytes
        send_frame(20, 16'd20, 1'b1, 1, 0, -1, "R9");     // ends before cut point
        send_frame(10, 16'd0, 1'b1, 1, 0, -1, "R9");      // ends inside header
        tick(1'b1, 8'hAA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R10");
        tick(1'b1, 8'h55, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R10");
        send_frame(64, 16'd5, 1'b1, 1, 0, 3, "R11");      // disabled mid-frame: still cut
        send_frame(64, 16'd5, 1'b0, 1, 0, 3, "R11");      // enabled mid-frame: no cut
        send_frame(8, 16'd3, 1'b1, 0, 0, -1, "R12");      // abandoned in header
        send_frame(20, 16'd3, 1'b1, 0, 0, -1, "R12");     // abandoned while skipping
        send_frame(40, 16'd12, 1'b1, 1, 0, -1, "R12");
        tick(1'b1, 8'h77, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R10");
        idle(3, "R2");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule